// File: doc/BRIEF.md
# Banked Interrupt Controller with Fast-Interrupt Steering

This block collects level-sensitive interrupt lines, grouped in banks of 32, and drives two request outputs toward a processor: a normal interrupt and a fast interrupt. Software controls it through a 32-bit register port with a single-cycle write strobe and a combinational read path. Each bank has a mask with set and clear aliases and a software-trigger register. It also has a raw-input view and two pending views, split by output. Each line has its own register that holds a 6-bit priority and a bit that steers the line to the fast output.

A line is active when its input is high or its software-trigger bit is set. Active, unmasked lines that are steered to an output raise that output one clock later, provided the global enable is set. The number of the winning source is not tracked continuously. It is captured only when software writes a new-arbitration command bit, and it is held until the next such command. The command also drops the matching output for one cycle, after which the output is re-evaluated.

Top module: `intc_banked`

## Requirements
- R1: After reset, every bank mask reads all ones and every software-trigger register reads zero. Every line register reads zero, the control register reads 4 (global enable set), both outputs are low, offset 0x014 reads 1 and offset 0x000 reads the revision parameter.
- R2: Bank registers live at 0x080–0x09C. Address bits [6:5] give the bank and bits [4:2] give the register. Line k of bank b is input bit b*32+k. Offset 0x080 of a bank reads that bank's input levels. A bank number at or above NBANK ignores writes and reads zero.
- R3: Offset 0x084 is the read/write mask, where a 1 masks a line. Writing 0x088 clears the mask bits that are written as 1, and writing 0x08C sets them. Both aliases read zero.
- R4: Writing 0x090 ORs the data into the software-trigger register, and 0x090 reads that register back. Writing 0x094 clears the bits written as 1. A line is active when its input is high or its trigger bit is set.
- R5: Offset 0x098 reads active & ~mask & ~steer, and offset 0x09C reads active & ~mask & steer.
- R6: The register of line k in bank b sits at 0x100 + b*0x80 + k*4. Bits [7:2] hold the priority and bit 0 steers the line (1 = fast output, 0 = normal output). It reads back with the same layout and zeros elsewhere.
- R7: Bit 2 of the control register (0x048) is a global enable and reads back at bit 2. Each output rises one clock after an unmasked active line is steered to it while the enable is set. An enable of 0 holds both outputs low.
- R8: Writing control bit 0 captures, into offset 0x040, the number b*32+k of the normal-pending line with the largest priority value, with ties going to the lower number, or 0 if no line is pending. Control bit 1 does the same for fast-pending lines into 0x044. The capture uses the inputs present in the write cycle and is held until the next command.
- R9: A command bit forces the matching output low in the cycle after the write. The output then follows R7 again from the next clock.
- R10: Writing bit 1 of 0x010 returns all state to the R1 values. Bit 0 of 0x010 is stored and read back at bit 0.
- R11: Writes to 0x000, 0x014, 0x040, 0x044, 0x080, 0x098 and 0x09C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_in | input | NBANK*32 | Level-sensitive interrupt lines |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A hardware line can rise in the same clock in which software writes a new-arbitration command. The captured source number must then already include that line. The bench raises a top-priority line on the exact cycle of the command write and expects its number in the source register, not the number of the earlier winner. The bench also checks that the same command drops the output on the next clock and that the output comes back one clock after that.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LINES_PER_BANK = 32;
  localparam int MAX_BANKS      = 4;

  localparam logic [11:0] OFF_REV     = 12'h000;
  localparam logic [11:0] OFF_CFG     = 12'h010;
  localparam logic [11:0] OFF_STAT    = 12'h014;
  localparam logic [11:0] OFF_SRC_NRM = 12'h040;
  localparam logic [11:0] OFF_SRC_FST = 12'h044;
  localparam logic [11:0] OFF_CTRL    = 12'h048;
  localparam logic [11:0] OFF_LINE0   = 12'h100;

  typedef enum logic [2:0] {
    BR_RAW  = 3'd0,
    BR_MASK = 3'd1,
    BR_MCLR = 3'd2,
    BR_MSET = 3'd3,
    BR_TRIG = 3'd4,
    BR_TCLR = 3'd5,
    BR_PNRM = 3'd6,
    BR_PFST = 3'd7
  } bank_reg_e;
endpackage

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int PRIO_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   soft_rst,
  input  logic [31:0]            wdata,
  input  logic                   wr_mask,
  input  logic                   wr_mclr,
  input  logic                   wr_mset,
  input  logic                   wr_tset,
  input  logic                   wr_tclr,
  input  logic                   wr_line,
  input  logic [4:0]             line_idx,
  input  logic [31:0]            raw_in,
  output logic [31:0]            mask_o,
  output logic [31:0]            trig_o,
  output logic [31:0]            steer_o,
  output logic [32*PRIO_W-1:0]   prio_o,
  output logic [31:0]            pend_nrm_o,
  output logic [31:0]            pend_fst_o
);
  localparam int NLINE = intc_pkg::LINES_PER_BANK;

  logic [31:0]       mask_q, trig_q, steer_q;
  logic [PRIO_W-1:0] prio_q [NLINE];
  logic [31:0]       active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      trig_q  <= '0;
      steer_q <= '0;
      for (int i = 0; i < NLINE; i++) prio_q[i] <= '0;
    end else if (soft_rst) begin
      mask_q  <= '1;
      trig_q  <= '0;
      steer_q <= '0;
      for (int i = 0; i < NLINE; i++) prio_q[i] <= '0;
    end else begin
      if (wr_mask) mask_q <= wdata;
      if (wr_mclr) mask_q <= mask_q & ~wdata;
      if (wr_mset) mask_q <= mask_q | wdata;
      if (wr_tset) trig_q <= trig_q | wdata;
      if (wr_tclr) trig_q <= trig_q & ~wdata;
      if (wr_line) begin
        prio_q[line_idx]  <= wdata[2 +: PRIO_W];
        steer_q[line_idx] <= wdata[0];
      end
    end
  end

  assign active     = raw_in | trig_q;
  assign pend_nrm_o = active & ~mask_q & ~steer_q;
  assign pend_fst_o = active & ~mask_q & steer_q;
  assign mask_o     = mask_q;
  assign trig_o     = trig_q;
  assign steer_o    = steer_q;

  for (genvar i = 0; i < NLINE; i++) begin : g_prio
    assign prio_o[i*PRIO_W +: PRIO_W] = prio_q[i];
  end

  // R3: the set alias leaves every written bit masked
  p_mset_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mset && !soft_rst) |=> ((mask_q & $past(wdata)) == $past(wdata)));
  // R4: the clear alias drops every written trigger bit
  p_tclr_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tclr && !wr_tset && !soft_rst) |=> ((trig_q & $past(wdata)) == 32'd0));
  // R10: soft reset restores mask and trigger state
  p_soft_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mask_q == '1 && trig_q == '0 && steer_q == '0));
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int NL     = 64,
  parameter int PRIO_W = 6,
  parameter int SRC_W  = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NL-1:0]        pend,
  input  logic [NL*PRIO_W-1:0] prio,
  output logic                 any_o,
  output logic [SRC_W-1:0]     win_o
);
  // Largest priority value wins; a strict compare keeps the lower number on ties.
  function automatic logic [SRC_W-1:0] pick_winner(
    input logic [NL-1:0] p, input logic [NL*PRIO_W-1:0] pr);
    logic [PRIO_W-1:0] best;
    logic              found;
    logic [SRC_W-1:0]  w;
    best  = '0;
    found = 1'b0;
    w     = '0;
    for (int i = 0; i < NL; i++) begin
      if (p[i] && (!found || pr[i*PRIO_W +: PRIO_W] > best)) begin
        found = 1'b1;
        best  = pr[i*PRIO_W +: PRIO_W];
        w     = SRC_W'(i);
      end
    end
    return w;
  endfunction

  assign any_o = |pend;
  assign win_o = any_o ? pick_winner(pend, prio) : '0;

  // R8: a reported winner is always a pending line
  p_winner_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> pend[win_o]);
endmodule

// File: rtl/intc_banked.sv
module intc_banked #(
  parameter int          NBANK  = 2,
  parameter int          PRIO_W = 6,
  parameter logic [31:0] REV    = 32'h0000_0021
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [11:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NBANK*32-1:0] irq_in,
  output logic                irq_o,
  output logic                fiq_o
);
  import intc_pkg::*;

  localparam int NL    = NBANK * LINES_PER_BANK;
  localparam int SRC_W = (NL > 1) ? $clog2(NL) : 1;

  // ---------------- address decode ----------------
  logic        bank_hit, bank_ok, line_hit;
  logic [1:0]  bank_sel, line_bank;
  logic [2:0]  breg;
  logic [4:0]  line_idx;
  logic [11:0] line_off;
  logic        soft_rst, cmd_nrm, cmd_fst, wr_ctrl, wr_cfg;

  assign bank_hit  = (bus_addr[11:7] == 5'b00001);
  assign bank_sel  = bus_addr[6:5];
  assign breg      = bus_addr[4:2];
  assign bank_ok   = bank_hit && (int'(bank_sel) < NBANK);
  assign line_off  = bus_addr - OFF_LINE0;
  assign line_hit  = (bus_addr >= OFF_LINE0) && (int'(line_off[11:7]) < NBANK);
  assign line_bank = line_off[8:7];
  assign line_idx  = bus_addr[6:2];

  assign wr_cfg   = bus_wr && (bus_addr == OFF_CFG);
  assign wr_ctrl  = bus_wr && (bus_addr == OFF_CTRL);
  assign soft_rst = wr_cfg && bus_wdata[1];
  assign cmd_nrm  = wr_ctrl && bus_wdata[0];
  assign cmd_fst  = wr_ctrl && bus_wdata[1];

  // ---------------- banks ----------------
  logic [31:0]          mask_b  [MAX_BANKS];
  logic [31:0]          trig_b  [MAX_BANKS];
  logic [31:0]          steer_b [MAX_BANKS];
  logic [31:0]          pnrm_b  [MAX_BANKS];
  logic [31:0]          pfst_b  [MAX_BANKS];
  logic [31:0]          raw_b   [MAX_BANKS];
  logic [NL-1:0]        pend_nrm, pend_fst;
  logic [NL*PRIO_W-1:0] prio_all;

  for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
    if (b < NBANK) begin : g_live
      logic sel_b, sel_l;
      assign sel_b     = bus_wr && bank_hit && (bank_sel == 2'(b));
      assign sel_l     = bus_wr && line_hit && (line_bank == 2'(b));
      assign raw_b[b]  = irq_in[b*32 +: 32];
      intc_bank #(.PRIO_W(PRIO_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .wdata      (bus_wdata),
        .wr_mask    (sel_b && breg == BR_MASK),
        .wr_mclr    (sel_b && breg == BR_MCLR),
        .wr_mset    (sel_b && breg == BR_MSET),
        .wr_tset    (sel_b && breg == BR_TRIG),
        .wr_tclr    (sel_b && breg == BR_TCLR),
        .wr_line    (sel_l),
        .line_idx   (line_idx),
        .raw_in     (irq_in[b*32 +: 32]),
        .mask_o     (mask_b[b]),
        .trig_o     (trig_b[b]),
        .steer_o    (steer_b[b]),
        .prio_o     (prio_all[b*32*PRIO_W +: 32*PRIO_W]),
        .pend_nrm_o (pnrm_b[b]),
        .pend_fst_o (pfst_b[b])
      );
      assign pend_nrm[b*32 +: 32] = pnrm_b[b];
      assign pend_fst[b*32 +: 32] = pfst_b[b];
    end else begin : g_absent
      assign mask_b[b]  = '0;
      assign trig_b[b]  = '0;
      assign steer_b[b] = '0;
      assign pnrm_b[b]  = '0;
      assign pfst_b[b]  = '0;
      assign raw_b[b]   = '0;
    end
  end

  // ---------------- arbitration, one per output ----------------
  logic             any_nrm, any_fst;
  logic [SRC_W-1:0] win_nrm, win_fst;

  intc_arb #(.NL(NL), .PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_arb_nrm (
    .clk(clk), .rst_n(rst_n), .pend(pend_nrm), .prio(prio_all),
    .any_o(any_nrm), .win_o(win_nrm));
  intc_arb #(.NL(NL), .PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_arb_fst (
    .clk(clk), .rst_n(rst_n), .pend(pend_fst), .prio(prio_all),
    .any_o(any_fst), .win_o(win_fst));

  // ---------------- global state and outputs ----------------
  logic             gen_en_q, idle_q, irq_q, fiq_q;
  logic [SRC_W-1:0] src_nrm_q, src_fst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en_q  <= 1'b1;
      idle_q    <= 1'b0;
      irq_q     <= 1'b0;
      fiq_q     <= 1'b0;
      src_nrm_q <= '0;
      src_fst_q <= '0;
    end else if (soft_rst) begin
      gen_en_q  <= 1'b1;
      idle_q    <= 1'b0;
      irq_q     <= 1'b0;
      fiq_q     <= 1'b0;
      src_nrm_q <= '0;
      src_fst_q <= '0;
    end else begin
      if (wr_cfg)  idle_q   <= bus_wdata[0];
      if (wr_ctrl) gen_en_q <= bus_wdata[2];
      if (cmd_nrm) src_nrm_q <= win_nrm;
      if (cmd_fst) src_fst_q <= win_fst;
      irq_q <= any_nrm && gen_en_q && !cmd_nrm;
      fiq_q <= any_fst && gen_en_q && !cmd_fst;
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  // ---------------- read path ----------------
  logic [SRC_W+5:0] gline;
  assign gline = SRC_W'(0) + {line_bank, line_idx};

  always_comb begin
    bus_rdata = '0;
    if (bank_ok) begin
      unique case (bank_reg_e'(breg))
        BR_RAW:  bus_rdata = raw_b[bank_sel];
        BR_MASK: bus_rdata = mask_b[bank_sel];
        BR_TRIG: bus_rdata = trig_b[bank_sel];
        BR_PNRM: bus_rdata = pnrm_b[bank_sel];
        BR_PFST: bus_rdata = pfst_b[bank_sel];
        default: bus_rdata = '0;
      endcase
    end else if (line_hit) begin
      bus_rdata = 32'(prio_all[int'(gline)*PRIO_W +: PRIO_W]) << 2;
      bus_rdata[0] = steer_b[line_bank][line_idx];
    end else begin
      case (bus_addr)
        OFF_REV:     bus_rdata = REV;
        OFF_CFG:     bus_rdata = {31'd0, idle_q};
        OFF_STAT:    bus_rdata = 32'd1;
        OFF_SRC_NRM: bus_rdata = 32'(src_nrm_q);
        OFF_SRC_FST: bus_rdata = 32'(src_fst_q);
        OFF_CTRL:    bus_rdata = {29'd0, gen_en_q, 2'b00};
        default:     bus_rdata = '0;
      endcase
    end
  end

  // R9: a command drops its output on the next clock
  p_cmd_drops_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_nrm |=> !irq_o);
  p_cmd_drops_fiq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fst |=> !fiq_o);
  // R7: a cleared global enable keeps both outputs low
  p_enable_gates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en_q |=> (!irq_o && !fiq_o));
  // R8: captured source numbers hold between commands
  p_src_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_nrm && !cmd_fst && !soft_rst) |=> ($stable(src_nrm_q) && $stable(src_fst_q)));
endmodule

// File: tb/intc_banked_test.sv
module intc_banked_test;
  localparam int NBANK = 2;
  localparam logic [31:0] REV = 32'h0000_0021;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                bus_wr = 1'b0;
  logic [11:0]         bus_addr = '0;
  logic [31:0]         bus_wdata = '0;
  logic [31:0]         bus_rdata;
  logic [NBANK*32-1:0] irq_in = '0;
  logic                irq_o, fiq_o;

  int total = 0;
  int bad   = 0;

  intc_banked #(.NBANK(NBANK), .PRIO_W(6), .REV(REV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .irq_o(irq_o), .fiq_o(fiq_o));

  always #5 clk = ~clk;

  // vector: {write enable, write addr, write data, read addr, expected}
  localparam int NV = 21;
  localparam logic [88:0] VEC [NV] = '{
    {1'b1, 12'h084, 32'h0000FFFF, 12'h084, 32'h0000FFFF}, // R3
    {1'b1, 12'h088, 32'h0000000F, 12'h084, 32'h0000FFF0}, // R3
    {1'b1, 12'h08C, 32'h00010000, 12'h084, 32'h0001FFF0}, // R3
    {1'b0, 12'h000, 32'h00000000, 12'h088, 32'h00000000}, // R3
    {1'b1, 12'h090, 32'h00000005, 12'h090, 32'h00000005}, // R4
    {1'b1, 12'h090, 32'h00000100, 12'h090, 32'h00000105}, // R4
    {1'b1, 12'h094, 32'h00000004, 12'h090, 32'h00000101}, // R4
    {1'b1, 12'h104, 32'hFFFFFFFF, 12'h104, 32'h000000FD}, // R6
    {1'b0, 12'h000, 32'h00000000, 12'h098, 32'h00000001}, // R5
    {1'b1, 12'h100, 32'h00000001, 12'h09C, 32'h00000001}, // R5
    {1'b0, 12'h000, 32'h00000000, 12'h098, 32'h00000000}, // R5
    {1'b1, 12'h0A4, 32'h00000000, 12'h0A4, 32'h00000000}, // R2
    {1'b0, 12'h000, 32'h00000000, 12'h084, 32'h0001FFF0}, // R2
    {1'b1, 12'h080, 32'hFFFFFFFF, 12'h080, 32'h00000000}, // R11
    {1'b1, 12'h09C, 32'h00000000, 12'h09C, 32'h00000001}, // R11
    {1'b1, 12'h040, 32'h0000FFFF, 12'h040, 32'h00000000}, // R11
    {1'b1, 12'h014, 32'h00000000, 12'h014, 32'h00000001}, // R11
    {1'b1, 12'h0C4, 32'h00001234, 12'h0C4, 32'h00000000}, // R2
    {1'b1, 12'h010, 32'h00000001, 12'h010, 32'h00000001}, // R10
    {1'b1, 12'h048, 32'h00000000, 12'h048, 32'h00000000}, // R7
    {1'b1, 12'h048, 32'h00000004, 12'h048, 32'h00000004}  // R7
  };
  localparam int VREQ [NV] = '{3,3,3,3,4,4,4,6,5,5,5,2,2,11,11,11,11,2,10,7,7};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R1 reset state
    rdchk("R1 mask", 12'h084, 32'hFFFFFFFF);
    rdchk("R1 trig", 12'h090, 32'h0);
    rdchk("R1 line", 12'h104, 32'h0);
    rdchk("R1 ctrl", 12'h048, 32'h4);
    rdchk("R1 status", 12'h014, 32'h1);
    rdchk("R1 rev", 12'h000, REV);
    check("R1 irq_o", {31'd0, irq_o}, 32'd0);
    check("R1 fiq_o", {31'd0, fiq_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      if (VEC[i][88]) wr(VEC[i][87:76], VEC[i][75:44]);
      rd(VEC[i][43:32], v);
      total++;
      if (v !== VEC[i][31:0]) begin
        bad++;
        $display("FAIL R%0d vector %0d: actual=0x%08h expected=0x%08h",
                 VREQ[i], i, v, VEC[i][31:0]);
      end
    end

    // R10 soft reset
    wr(12'h010, 32'h2);
    rdchk("R10 mask", 12'h084, 32'hFFFFFFFF);
    rdchk("R10 trig", 12'h090, 32'h0);
    rdchk("R10 line", 12'h104, 32'h0);
    rdchk("R10 idle", 12'h010, 32'h0);

    // R2 raw input view for bank 1
    irq_in[35] = 1'b1;
    rdchk("R2 raw bank1", 12'h0A0, 32'h8);
    rdchk("R2 raw bank0", 12'h080, 32'h0);
    irq_in[35] = 1'b0;

    // R7 output steering and global enable
    irq_in[5] = 1'b1;
    wr(12'h084, 32'h0);
    tick();
    check("R7 irq_o up", {31'd0, irq_o}, 32'd1);
    check("R7 fiq_o idle", {31'd0, fiq_o}, 32'd0);
    wr(12'h114, 32'h1);
    tick();
    check("R7 fiq_o steered", {31'd0, fiq_o}, 32'd1);
    check("R7 irq_o steered away", {31'd0, irq_o}, 32'd0);
    wr(12'h048, 32'h0);
    tick();
    check("R7 disabled", {30'd0, irq_o, fiq_o}, 32'd0);
    wr(12'h048, 32'h4);

    // R8 arbitration: tie at priority 7 between lines 9 and 34
    wr(12'h114, 32'h0C);
    wr(12'h124, 32'h1C);
    wr(12'h0A4, 32'h0);
    wr(12'h188, 32'h1C);
    irq_in[9] = 1'b1; irq_in[34] = 1'b1;
    tick();
    check("R7 irq_o before cmd", {31'd0, irq_o}, 32'd1);
    wr(12'h048, 32'h5);
    check("R9 irq_o dropped", {31'd0, irq_o}, 32'd0);
    rdchk("R8 tie to lower", 12'h040, 32'd9);
    tick();
    check("R9 irq_o back", {31'd0, irq_o}, 32'd1);
    wr(12'h188, 32'h20);
    rdchk("R8 held", 12'h040, 32'd9);
    wr(12'h048, 32'h5);
    rdchk("R8 higher prio", 12'h040, 32'd34);

    // R8/R9 fast output
    wr(12'h188, 32'h21);
    tick();
    check("R7 fiq_o up", {31'd0, fiq_o}, 32'd1);
    wr(12'h048, 32'h6);
    check("R9 fiq_o dropped", {31'd0, fiq_o}, 32'd0);
    rdchk("R8 fast src", 12'h044, 32'd34);
    rdchk("R8 normal src untouched", 12'h040, 32'd34);
    tick();
    check("R9 fiq_o back", {31'd0, fiq_o}, 32'd1);

    // R8 line rising in the same cycle as the command
    wr(12'h1A0, 32'hFC);
    @(negedge clk);
    irq_in[40] = 1'b1;
    bus_wr = 1'b1; bus_addr = 12'h048; bus_wdata = 32'h5;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    rdchk("R8 same-cycle arrival", 12'h040, 32'd40);

    // R8 nothing pending
    irq_in = '0;
    wr(12'h048, 32'h5);
    rdchk("R8 none pending", 12'h040, 32'd0);
    tick();
    check("R7 outputs idle", {30'd0, irq_o, fiq_o}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule